// File: doc/BRIEF.md
# Receive Frame Status Trailer Generator

This block sits at the tail of a MAC receive path, between the byte stream coming off the line logic and the receive DMA. Each byte of an accepted frame is forwarded one clock later. When the frame ends, the block appends four status bytes. These give the frame's length in bytes (twelve bits, with the FCS bytes included), four error flags, and the values of two statistics counters. Software reading the buffer afterwards finds the status at a fixed place after the data. The payload length is the reported count minus four.

The block also holds three 8-bit event counters: runt frames, receive collisions and missed frames. When a counter rolls over, it sets an overflow bit in an 8-bit interrupt register. The same register collects four externally detected conditions and a per-frame receive-done bit. The register bits are sticky and a read strobe clears them. A mask register decides which set bits drive the single interrupt line.

Top module: `rxst_trailer_gen`

## Requirements
- R1: Every byte accepted as part of a frame appears on `st_data` with `st_valid` high exactly one cycle after the cycle in which it was presented, in the same order. A frame opens with a byte that has `rx_valid` and `rx_sof` high. Later bytes need `rx_valid` high.
- R2: When a frame ends, four trailer bytes follow on consecutive cycles. Trailer byte 0 appears two cycles after the ending cycle. The bytes are: 0 = byte count [7:0]; 1 = {overflow (bit 7), collision (bit 6), framing error (bit 5), FCS error (bit 4), byte count [11:8] (bits 3:0)}; 2 = runt counter; 3 = receive-collision counter. `st_last` is high with trailer byte 3 and at no other time.
- R3: The byte count covers every forwarded byte of the frame, FCS bytes included. It saturates at 4095 and does not wrap.
- R4: The collision, framing-error and FCS-error flags are set in trailer byte 1 if the matching input was high in any cycle from the opening byte through the ending cycle.
- R5: A frame can be ended by `rx_abort` instead of `rx_eof`. An aborted frame still gets a trailer, with the overflow flag (byte 1 bit 7) set and the count equal to the bytes already forwarded. A byte presented in the abort cycle is not forwarded.
- R6: Input bytes are ignored in the four cycles after a frame's ending cycle. They are also ignored outside a frame when `rx_sof` is low. Such bytes produce no output.
- R7: Trailer bytes 2 and 3 show how many `ev_runt` and `ev_rx_coll` cycles occurred before the frame's ending cycle, modulo 256.
- R8: When a counter steps from 255 to 0, it sets an interrupt bit, visible on the next cycle: runt counter sets bit 3 (0x08), receive-collision counter sets bit 4 (0x10), missed-frame counter (`ev_missed`) sets bit 2 (0x04).
- R9: The receive-done bit, bit 1 (0x02), is set in the cycle after `st_last` was high.
- R10: The external sources set their interrupt bits on the cycle after their strobe: jabber bit 7 (0x80), babble bit 6 (0x40), collision error bit 5 (0x20), transmit done bit 0 (0x01).
- R11: Interrupt bits stay set until `irq_rd` is high for a cycle, which clears every bit the next cycle. A source strobing in that same cycle leaves its bit set.
- R12: `irq_mask` is written from `mask_wdata` when `mask_we` is high and shows the new value the next cycle. A set mask bit suppresses that source. `irq` is high exactly when some bit is set in `irq_status` and clear in `irq_mask`.
- R13: After reset, `st_valid` and `st_last` are low, `irq_status` is 0, `irq_mask` is 0xFF, `irq` is low, and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Input byte present |
| rx_data | input | 8 | Input byte |
| rx_sof | input | 1 | Byte opens a frame |
| rx_eof | input | 1 | Byte is the frame's last |
| rx_abort | input | 1 | Frame ends because the line FIFO overflowed |
| rx_coll | input | 1 | Collision seen during the frame |
| rx_fram_err | input | 1 | Framing error seen during the frame |
| rx_fcs_err | input | 1 | FCS check failed |
| ev_runt | input | 1 | Runt frame discarded (counted) |
| ev_rx_coll | input | 1 | Receive collision (counted) |
| ev_missed | input | 1 | Frame missed (counted) |
| ev_jabber | input | 1 | Jabber condition strobe |
| ev_babble | input | 1 | Babble condition strobe |
| ev_coll_err | input | 1 | Collision error strobe |
| ev_tx_done | input | 1 | Transmit done strobe |
| st_valid | output | 1 | Output byte present |
| st_data | output | 8 | Output byte (frame data or trailer) |
| st_last | output | 1 | Final trailer byte |
| irq_rd | input | 1 | Read strobe, clears interrupt bits |
| irq_status | output | 8 | Sticky interrupt bits |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New mask value |
| irq_mask | output | 8 | Current mask |
| irq | output | 1 | Unmasked interrupt request |

## Verification
Wrong internal state shows up at the ports within a few cycles. A byte counter that slips or a flag that drops shows in the trailer two to five cycles after the frame ends. A trailer index that is off moves `st_last` or the trailer start by a cycle. A counter that miscounts shows in the trailer of the next frame, and a wrong rollover point moves the overflow bit from where 256 strobes predict. Interrupt bits that fail to stick, or a clear that beats a same-cycle set, change `irq_status` on the next cycle. A mask fault shows at once on `irq`.

// File: rtl/rxst_pkg.sv
package rxst_pkg;
    localparam int BYTE_W  = 8;
    localparam int BCNT_W  = 12;
    localparam int TRL_LEN = 4;
    localparam int EVC_W   = 8;
    localparam int NUM_EVC = 3;
    localparam int IRQ_W   = 8;

    // event counter slots
    localparam int EVC_RUNT = 0;
    localparam int EVC_RCOL = 1;
    localparam int EVC_MISS = 2;

    // interrupt bit positions
    localparam int IRQ_JAB    = 7;
    localparam int IRQ_BABL   = 6;
    localparam int IRQ_CERR   = 5;
    localparam int IRQ_RCOLOV = 4;
    localparam int IRQ_RNTOV  = 3;
    localparam int IRQ_MISSOV = 2;
    localparam int IRQ_RCV    = 1;
    localparam int IRQ_XMT    = 0;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_BODY  = 2'd1,
        FR_TRAIL = 2'd2
    } fr_state_e;
endpackage

// File: rtl/rxst_evbank.sv
module rxst_evbank
    import rxst_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVC-1:0] inc,
    output logic [NUM_EVC-1:0] wrap,
    output logic [EVC_W-1:0]   cnt_runt,
    output logic [EVC_W-1:0]   cnt_rcol
);
    localparam logic [EVC_W-1:0] CNT_MAX = '1;

    logic [NUM_EVC-1:0][EVC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        for (int i = 0; i < NUM_EVC; i++) begin
            cnt_d[i] = inc[i] ? cnt_q[i] + EVC_W'(1) : cnt_q[i];
            wrap[i]  = inc[i] && (cnt_q[i] == CNT_MAX);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_runt = cnt_q[EVC_RUNT];
    assign cnt_rcol = cnt_q[EVC_RCOL];
endmodule

// File: rtl/rxst_irqreg.sv
module rxst_irqreg
    import rxst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_vec,
    input  logic             rd_clr,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_wdata,
    output logic [IRQ_W-1:0] status,
    output logic [IRQ_W-1:0] mask,
    output logic             irq
);
    typedef struct packed {
        logic [IRQ_W-1:0] stat;
        logic [IRQ_W-1:0] msk;
    } ir_t;

    ir_t d, q;

    always_comb begin
        d      = q;
        // a set in the clearing cycle survives
        d.stat = (rd_clr ? '0 : q.stat) | set_vec;
        if (mask_we) d.msk = mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.stat <= '0;
            q.msk  <= '1;
        end else begin
            q <= d;
        end
    end

    assign status = q.stat;
    assign mask   = q.msk;
    assign irq    = |(q.stat & ~q.msk);
endmodule

// File: rtl/rxst_framer.sv
module rxst_framer
    import rxst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_abort,
    input  logic              in_coll,
    input  logic              in_fram_err,
    input  logic              in_fcs_err,
    input  logic [EVC_W-1:0]  trl_runt,
    input  logic [EVC_W-1:0]  trl_rcol,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last
);
    localparam int              IDX_W    = $clog2(TRL_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TRL_LEN - 1);
    localparam logic [BCNT_W-1:0] BCNT_MAX = '1;

    typedef struct packed {
        fr_state_e          st;
        logic [IDX_W-1:0]   idx;
        logic [BCNT_W-1:0]  bcnt;
        logic               f_oflo;
        logic               f_coll;
        logic               f_fram;
        logic               f_fcs;
        logic [EVC_W-1:0]   snap_runt;
        logic [EVC_W-1:0]   snap_rcol;
        logic               ov;
        logic [BYTE_W-1:0]  od;
        logic               ol;
    } fr_t;

    fr_t d, q;
    logic              end_frame;
    logic [BYTE_W-1:0] trl_byte;

    always_comb begin
        case (q.idx)
            IDX_W'(0): trl_byte = q.bcnt[BYTE_W-1:0];
            IDX_W'(1): trl_byte = {q.f_oflo, q.f_coll, q.f_fram, q.f_fcs,
                                   q.bcnt[BCNT_W-1:BYTE_W]};
            IDX_W'(2): trl_byte = q.snap_runt;
            default:   trl_byte = q.snap_rcol;
        endcase
    end

    always_comb begin
        d         = q;
        d.ov      = 1'b0;
        d.ol      = 1'b0;
        end_frame = 1'b0;
        case (q.st)
            FR_IDLE: begin
                if (in_valid && in_sof && !in_abort) begin
                    d.ov     = 1'b1;
                    d.od     = in_data;
                    d.bcnt   = BCNT_W'(1);
                    d.f_oflo = 1'b0;
                    d.f_coll = in_coll;
                    d.f_fram = in_fram_err;
                    d.f_fcs  = in_fcs_err;
                    d.st     = FR_BODY;
                    end_frame = in_eof;
                end
            end
            FR_BODY: begin
                d.f_coll = q.f_coll | in_coll;
                d.f_fram = q.f_fram | in_fram_err;
                d.f_fcs  = q.f_fcs  | in_fcs_err;
                if (in_abort) begin
                    d.f_oflo  = 1'b1;
                    end_frame = 1'b1;
                end else if (in_valid) begin
                    d.ov = 1'b1;
                    d.od = in_data;
                    if (q.bcnt != BCNT_MAX) d.bcnt = q.bcnt + BCNT_W'(1);
                    end_frame = in_eof;
                end
            end
            FR_TRAIL: begin
                d.ov  = 1'b1;
                d.od  = trl_byte;
                d.ol  = (q.idx == IDX_LAST);
                d.idx = q.idx + IDX_W'(1);
                if (q.idx == IDX_LAST) d.st = FR_IDLE;
            end
            default: d.st = FR_IDLE;
        endcase
        if (end_frame) begin
            d.st        = FR_TRAIL;
            d.idx       = '0;
            d.snap_runt = trl_runt;
            d.snap_rcol = trl_rcol;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.ov;
    assign out_data  = q.od;
    assign out_last  = q.ol;
endmodule

// File: rtl/rxst_trailer_gen.sv
module rxst_trailer_gen
    import rxst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_abort,
    input  logic        rx_coll,
    input  logic        rx_fram_err,
    input  logic        rx_fcs_err,
    input  logic        ev_runt,
    input  logic        ev_rx_coll,
    input  logic        ev_missed,
    input  logic        ev_jabber,
    input  logic        ev_babble,
    input  logic        ev_coll_err,
    input  logic        ev_tx_done,
    output logic        st_valid,
    output logic [7:0]  st_data,
    output logic        st_last,
    input  logic        irq_rd,
    output logic [7:0]  irq_status,
    input  logic        mask_we,
    input  logic [7:0]  mask_wdata,
    output logic [7:0]  irq_mask,
    output logic        irq
);
    logic [NUM_EVC-1:0] evc_inc;
    logic [NUM_EVC-1:0] evc_wrap;
    logic [EVC_W-1:0]   cnt_runt;
    logic [EVC_W-1:0]   cnt_rcol;
    logic [IRQ_W-1:0]   set_vec;
    logic               fr_last;

    always_comb begin
        evc_inc           = '0;
        evc_inc[EVC_RUNT] = ev_runt;
        evc_inc[EVC_RCOL] = ev_rx_coll;
        evc_inc[EVC_MISS] = ev_missed;
    end

    rxst_evbank u_evbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (evc_inc),
        .wrap     (evc_wrap),
        .cnt_runt (cnt_runt),
        .cnt_rcol (cnt_rcol)
    );

    rxst_framer u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (rx_valid),
        .in_data     (rx_data),
        .in_sof      (rx_sof),
        .in_eof      (rx_eof),
        .in_abort    (rx_abort),
        .in_coll     (rx_coll),
        .in_fram_err (rx_fram_err),
        .in_fcs_err  (rx_fcs_err),
        .trl_runt    (cnt_runt),
        .trl_rcol    (cnt_rcol),
        .out_valid   (st_valid),
        .out_data    (st_data),
        .out_last    (fr_last)
    );

    assign st_last = fr_last;

    always_comb begin
        set_vec             = '0;
        set_vec[IRQ_JAB]    = ev_jabber;
        set_vec[IRQ_BABL]   = ev_babble;
        set_vec[IRQ_CERR]   = ev_coll_err;
        set_vec[IRQ_RCOLOV] = evc_wrap[EVC_RCOL];
        set_vec[IRQ_RNTOV]  = evc_wrap[EVC_RUNT];
        set_vec[IRQ_MISSOV] = evc_wrap[EVC_MISS];
        set_vec[IRQ_RCV]    = fr_last;
        set_vec[IRQ_XMT]    = ev_tx_done;
    end

    rxst_irqreg u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .rd_clr     (irq_rd),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .status     (irq_status),
        .mask       (irq_mask),
        .irq        (irq)
    );
endmodule

// File: rtl/rxst_trailer_chk.sv
module rxst_trailer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       st_valid,
    input logic       st_last,
    input logic       irq_rd,
    input logic [7:0] irq_status,
    input logic       mask_we,
    input logic [7:0] mask_wdata,
    input logic [7:0] irq_mask,
    input logic       irq
);
    // R2: the closing trailer byte is a real output byte
    a_r2_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        st_last |-> st_valid);

    // R9: receive-done bit follows the closing byte
    a_r9_rcv_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        st_last |=> irq_status[1]);

    // R11: without a read no bit drops
    a_r11_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_rd |=> ((irq_status & $past(irq_status)) == $past(irq_status)));

    // R12: mask write lands next cycle
    a_r12_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (irq_mask == $past(mask_wdata)));

    // R12: a fully set mask keeps the line quiet
    a_r12_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 8'hFF) |-> !irq);
endmodule

bind rxst_trailer_gen rxst_trailer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_last    (st_last),
    .irq_rd     (irq_rd),
    .irq_status (irq_status),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .irq_mask   (irq_mask),
    .irq        (irq)
);

// File: tb/sim_rxst_trailer_gen.sv
module sim_rxst_trailer_gen;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_abort = 0;
    logic [7:0] rx_data = 0;
    logic       rx_coll = 0, rx_fram_err = 0, rx_fcs_err = 0;
    logic       ev_runt = 0, ev_rx_coll = 0, ev_missed = 0;
    logic       ev_jabber = 0, ev_babble = 0, ev_coll_err = 0, ev_tx_done = 0;
    logic       st_valid, st_last, irq;
    logic [7:0] st_data, irq_status, irq_mask;
    logic       irq_rd = 0, mask_we = 0;
    logic [7:0] mask_wdata = 0;

    rxst_trailer_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_abort(rx_abort), .rx_coll(rx_coll), .rx_fram_err(rx_fram_err),
        .rx_fcs_err(rx_fcs_err), .ev_runt(ev_runt), .ev_rx_coll(ev_rx_coll),
        .ev_missed(ev_missed), .ev_jabber(ev_jabber), .ev_babble(ev_babble),
        .ev_coll_err(ev_coll_err), .ev_tx_done(ev_tx_done),
        .st_valid(st_valid), .st_data(st_data), .st_last(st_last),
        .irq_rd(irq_rd), .irq_status(irq_status), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .irq_mask(irq_mask), .irq(irq)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0;
    int exp_runt = 0, exp_rcol = 0;

    logic [7:0]  cap_d[$];
    logic        cap_l[$];
    int unsigned cap_c[$];

    always @(negedge clk) begin
        if (rst_n && st_valid) begin
            cap_d.push_back(st_data);
            cap_l.push_back(st_last);
            cap_c.push_back(cyc);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_in();
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_abort = 0; rx_data = 0;
        rx_coll = 0; rx_fram_err = 0; rx_fcs_err = 0;
    endtask

    task automatic pulse_ev(input int which, input int n);
        @(negedge clk);
        case (which)
            0: ev_runt = 1;     1: ev_rx_coll = 1;  2: ev_missed = 1;
            3: ev_jabber = 1;   4: ev_babble = 1;   5: ev_coll_err = 1;
            default: ev_tx_done = 1;
        endcase
        repeat (n) @(negedge clk);
        ev_runt = 0; ev_rx_coll = 0; ev_missed = 0; ev_jabber = 0;
        ev_babble = 0; ev_coll_err = 0; ev_tx_done = 0;
        @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_rd = 1;
        @(negedge clk); irq_rd = 0;
    endtask

    task automatic write_mask(input logic [7:0] v);
        @(negedge clk); mask_we = 1; mask_wdata = v;
        @(negedge clk); mask_we = 0;
    endtask

    // drives one frame and checks forwarded bytes and the trailer
    task automatic run_frame(input string tag, input int n, input logic [7:0] base,
                             input bit fcs_sof, input bit coll_mid, input bit fram_end,
                             input bit abort, input bit junk);
        int unsigned s_cyc = 0, e_cyc = 0;
        int cnt, bad, lasts;
        logic [7:0] b1;
        cap_d.delete(); cap_l.delete(); cap_c.delete();
        if (junk) begin
            repeat (2) begin
                @(negedge clk); idle_in(); rx_valid = 1; rx_data = 8'hEE;
            end
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idle_in();
            rx_valid    = 1;
            rx_data     = base + 8'(i);
            rx_sof      = (i == 0);
            rx_eof      = !abort && (i == n - 1);
            rx_fcs_err  = fcs_sof && (i == 0);
            rx_coll     = coll_mid && (i == n / 2);
            rx_fram_err = fram_end && !abort && (i == n - 1);
            if (i == 0) s_cyc = cyc;
            e_cyc = cyc;
        end
        if (abort) begin
            @(negedge clk);
            idle_in(); rx_abort = 1; rx_valid = 1; rx_data = 8'hAB; rx_fram_err = fram_end;
            e_cyc = cyc;
        end
        if (junk) begin
            repeat (4) begin
                @(negedge clk); idle_in();
                rx_valid = 1; rx_sof = 1; rx_eof = 1; rx_data = 8'h55;
            end
        end
        @(negedge clk); idle_in();
        repeat (6) @(negedge clk);

        cnt = (n > 4095) ? 4095 : n;
        b1  = {abort, coll_mid, fram_end, fcs_sof, 4'(cnt >> 8)};
        chk("R2", {tag, " output byte total"}, cap_d.size(), n + 4);
        if (cap_d.size() == n + 4) begin
            bad = 0; lasts = 0;
            for (int i = 0; i < n; i++) if (cap_d[i] !== base + 8'(i)) bad++;
            for (int i = 0; i < n + 4; i++) if (cap_l[i]) lasts++;
            chk("R1", {tag, " data bytes wrong"}, bad, 0);
            chk("R1", {tag, " first byte cycle"}, cap_c[0], s_cyc + 1);
            chk("R2", {tag, " trailer start cycle"}, cap_c[n], e_cyc + 2);
            chk("R2", {tag, " trailer span"}, cap_c[n+3] - cap_c[n], 3);
            chk("R3", {tag, " count low byte"}, cap_d[n], cnt & 8'hFF);
            chk("R4", {tag, " status byte"}, cap_d[n+1], b1);
            chk("R7", {tag, " runt byte"}, cap_d[n+2], exp_runt);
            chk("R7", {tag, " rx coll byte"}, cap_d[n+3], exp_rcol);
            chk("R2", {tag, " last flag on byte 3"}, cap_l[n+3], 1);
            chk("R2", {tag, " last flag count"}, lasts, 1);
        end
        chk("R9", {tag, " receive bit"}, irq_status[1], 1);
    endtask

    task automatic t_reset();
        chk("R13", "st_valid", st_valid, 0);
        chk("R13", "st_last", st_last, 0);
        chk("R13", "status", irq_status, 0);
        chk("R13", "mask", irq_mask, 8'hFF);
        chk("R13", "irq", irq, 0);
    endtask

    task automatic t_frames();
        run_frame("basic", 10, 8'h20, 0, 0, 0, 0, 0);
        clear_irq();
        @(negedge clk);
        chk("R11", "status after read", irq_status, 0);
        run_frame("flags", 70, 8'h90, 1, 1, 1, 0, 0);
        run_frame("long", 300, 8'h01, 0, 0, 0, 0, 0);
        run_frame("fcs_only", 1, 8'h7F, 1, 0, 0, 0, 0);
        run_frame("abort_R5", 5, 8'h40, 0, 0, 0, 1, 0);
        run_frame("ignore_R6", 4, 8'hC0, 0, 0, 0, 0, 1);
        run_frame("saturate_R3", 4100, 8'h00, 0, 0, 0, 0, 0);
    endtask

    task automatic t_counters();
        pulse_ev(0, 3); exp_runt = 3;
        pulse_ev(1, 5); exp_rcol = 5;
        run_frame("counts", 8, 8'h10, 0, 0, 0, 0, 0);
        clear_irq();
        pulse_ev(0, 253); exp_runt = 0;
        @(negedge clk);
        chk("R8", "runt wrap bit", irq_status & 8'h1C, 8'h08);
        pulse_ev(1, 251); exp_rcol = 0;
        @(negedge clk);
        chk("R8", "rx coll wrap bit", irq_status & 8'h1C, 8'h18);
        pulse_ev(2, 255);
        @(negedge clk);
        chk("R8", "missed no wrap at 255", irq_status & 8'h1C, 8'h18);
        pulse_ev(2, 1);
        @(negedge clk);
        chk("R8", "missed wrap bit", irq_status & 8'h1C, 8'h1C);
        run_frame("wrapped", 6, 8'h33, 0, 1, 0, 0, 0);
    endtask

    task automatic t_irq();
        clear_irq();
        pulse_ev(3, 1); pulse_ev(4, 1); pulse_ev(5, 1); pulse_ev(6, 1);
        chk("R10", "direct sources", irq_status, 8'hE1);
        repeat (5) @(negedge clk);
        chk("R11", "bits held", irq_status, 8'hE1);
        chk("R12", "irq masked", irq, 0);
        @(negedge clk); irq_rd = 1; ev_tx_done = 1;
        @(negedge clk); irq_rd = 0; ev_tx_done = 0;
        @(negedge clk);
        chk("R11", "set wins over clear", irq_status, 8'h01);
        write_mask(8'hFE);
        chk("R12", "mask value", irq_mask, 8'hFE);
        chk("R12", "irq unmasked tx", irq, 1);
        write_mask(8'hFD);
        chk("R12", "irq other bit unmasked", irq, 0);
        write_mask(8'hFF);
        chk("R12", "mask restored", irq_mask, 8'hFF);
    endtask

    initial begin
        repeat (200000 / 2) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_frames();
        t_counters();
        t_irq();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule